// File: doc/BRIEF.md
# Outgoing Data Error Marker

This block sits on the transmit path between a processor core and the system data bus. Every outgoing 64-bit beat arrives with its check bits, an ECC decode status and a cacheable attribute. The block turns each beat into the form the bus receiver must see. Beats whose uncorrectable error has already been tagged go out exactly as they came in. Beats carrying a raw uncorrectable error are replaced by a poison word that names the sending agent. Clean and correctable beats leave with check bits generated afresh.

The agent identifier comes from a small software-writable register inside the block. For every uncorrectable beat, a report-mode code travels with the beat. It tells the downstream logic whether the destination port must raise the error (noncacheable transfer) or whether the poison is stored and raised later by whoever consumes it (cacheable transfer). The source itself never raises a local report.

The marker is one register stage with valid/ready flow control on both sides.

Top module: `odm_marker`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and the agent ID register holds the parameter `RESET_ID`.
- R2: A beat with status 0 (clean) or 1 (correctable) leaves with its data unchanged and with freshly generated check bits. For k < 7, check bit k is the XOR of every data bit i for which bit k of (i+1) is set. Check bit 7 is the XOR of all 64 data bits.
- R3: A beat with status 3 (already-marked uncorrectable) leaves with both data and check bits bit-for-bit identical to its input.
- R4: A beat with status 2 (raw uncorrectable) leaves as the marked form. The data is the agent ID placed at bits [`MARK_ID_LSB`+7:`MARK_ID_LSB`] with every other bit zero. The check bits are the R2 code of that word XORed with the reserved syndrome `MARK_SYN`.
- R5: A pulse on `id_wr_en` loads `id_wr_data` into the agent ID register. A raw beat accepted on the same clock edge as a write is marked with the previous ID.
- R6: `out_report` is 1 (destination port reports) for an uncorrectable beat (status 2 or 3) that is noncacheable. It is 2 (report deferred to the consumer) for an uncorrectable beat that is cacheable. It is 0 for a clean or correctable beat.
- R7: A beat accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after that same edge, which gives one cycle of latency.
- R8: While `out_valid` is high and `out_ready` is low, every output stays stable and `in_ready` is low. Beats are never dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_wr_en | input | 1 | Write strobe for the agent ID register |
| id_wr_data | input | 8 | New agent ID value |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 64 | Input data word |
| in_check | input | 8 | Input check bits |
| in_status | input | 2 | Decode status: 0 clean, 1 correctable, 2 raw UE, 3 marked UE |
| in_cacheable | input | 1 | Transfer targets cacheable space |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Bus side accepts the beat |
| out_data | output | 64 | Output data word |
| out_check | output | 8 | Output check bits |
| out_report | output | 2 | Report mode: 0 none, 1 destination port, 2 on consumption |

## Verification
The bench builds the marker with `MARK_ID_LSB` = 40 and `RESET_ID` = 8'h3C rather than the defaults. A shifted ID field and a nonzero reset ID mean that a misplaced field, unzeroed surrounding bits, or a reset value of zero all change the expected word. The default `MARK_SYN` of 8'hC3 is kept, so poison check bits differ from a plain regeneration in both nibbles. Together these settings put the R4 and R5 cases within reach of value checks at the ports.

// File: rtl/odm_pkg.sv
// Package: shared encodings for the outgoing data error marker.
// Assumes a 2-bit decode status and a 2-bit report-mode code on the ports.
package odm_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_CORR   = 2'd1,
        ST_RAW_UE = 2'd2,
        ST_MRK_UE = 2'd3
    } beat_status_e;

    typedef enum logic [1:0] {
        RPT_NONE    = 2'd0,
        RPT_DEST    = 2'd1,
        RPT_CONSUME = 2'd2
    } report_mode_e;

endpackage

// File: rtl/odm_checkgen.sv
// Module: odm_checkgen
// Builds check bits for a data word. For k below CW-1, check bit k covers
// every data bit i where bit k of (i+1) is set. The top check bit covers the
// whole word.
// Assumes CW-1 >= clog2(DW+1), so that each data position has a code.
module odm_checkgen #(
    parameter int DW = 64,
    parameter int CW = 8
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] check
);

    // Returns the coverage mask of check bit k.
    function automatic logic [DW-1:0] col_mask(input int k);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) begin
            m[i] = (((i + 1) >> k) & 1) != 0;
        end
        return m;
    endfunction

    genvar k;
    generate
        for (k = 0; k < CW - 1; k++) begin : g_col
            localparam logic [DW-1:0] MASK = col_mask(k);
            // Parity over the data positions in column k.
            assign check[k] = ^(data & MASK);
        end
    endgenerate

    // Parity over the whole word.
    assign check[CW-1] = ^data;

endmodule

// File: rtl/odm_id_reg.sv
// Module: odm_id_reg
// Agent ID register that software writes. A write takes effect on the clock
// edge. Readers at that same edge still see the old value.
// Assumes a synchronous active-low reset.
module odm_id_reg #(
    parameter int              IDW      = 8,
    parameter logic [IDW-1:0]  RESET_ID = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_data,
    output logic [IDW-1:0] id_q
);

    // Load the ID on a write, or restore the reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= RESET_ID;
        end else if (wr_en) begin
            id_q <= wr_data;
        end
    end

endmodule

// File: rtl/odm_select.sv
// Module: odm_select
// Combinational choice of the outgoing word, check bits and report mode from
// the decode status and the cacheable attribute.
// Assumes the check codes of the input word and of the poison word are
// produced outside this module.
module odm_select #(
    parameter int             DW       = 64,
    parameter int             CW       = 8,
    parameter logic [CW-1:0]  MARK_SYN = 8'hC3
) (
    input  logic [1:0]    status,
    input  logic          cacheable,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] in_check,
    input  logic [CW-1:0] gen_in,
    input  logic [DW-1:0] mark_word,
    input  logic [CW-1:0] gen_mark,
    output logic [DW-1:0] nxt_data,
    output logic [CW-1:0] nxt_check,
    output logic [1:0]    nxt_report
);
    import odm_pkg::*;

    beat_status_e st;
    assign st = beat_status_e'(status);

    // Choose the data and check bits for each status.
    always_comb begin
        unique case (st)
            ST_MRK_UE: begin
                nxt_data  = in_data;
                nxt_check = in_check;
            end
            ST_RAW_UE: begin
                nxt_data  = mark_word;
                nxt_check = gen_mark ^ MARK_SYN;
            end
            default: begin
                nxt_data  = in_data;
                nxt_check = gen_in;
            end
        endcase
    end

    // Report mode: only uncorrectable beats carry one, keyed by cacheability.
    always_comb begin
        if (st == ST_RAW_UE || st == ST_MRK_UE) begin
            nxt_report = cacheable ? RPT_CONSUME : RPT_DEST;
        end else begin
            nxt_report = RPT_NONE;
        end
    end

endmodule

// File: rtl/odm_marker.sv
// Module: odm_marker (top)
// Outgoing data error marker with one register stage and valid/ready on both
// sides. Marked uncorrectable beats pass through untouched. Raw ones become a
// poison word carrying the agent ID and a reserved syndrome. Other beats get
// freshly generated check bits.
// Assumes MARK_ID_LSB + IDW <= DW and a synchronous active-low reset.
module odm_marker #(
    parameter int              DW          = 64,
    parameter int              CW          = 8,
    parameter int              IDW         = 8,
    parameter int              MARK_ID_LSB = 48,
    parameter logic [CW-1:0]   MARK_SYN    = 8'hC3,
    parameter logic [IDW-1:0]  RESET_ID    = 8'h01
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           id_wr_en,
    input  logic [IDW-1:0] id_wr_data,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [DW-1:0]  in_data,
    input  logic [CW-1:0]  in_check,
    input  logic [1:0]     in_status,
    input  logic           in_cacheable,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic [CW-1:0]  out_check,
    output logic [1:0]     out_report
);

    localparam int ID_MSB = MARK_ID_LSB + IDW - 1;

    logic [IDW-1:0] id_q;
    logic [DW-1:0]  mark_word;
    logic [CW-1:0]  gen_in;
    logic [CW-1:0]  gen_mark;
    logic [DW-1:0]  nxt_data;
    logic [CW-1:0]  nxt_check;
    logic [1:0]     nxt_report;
    logic           accept;

    odm_id_reg #(.IDW(IDW), .RESET_ID(RESET_ID)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (id_wr_en),
        .wr_data (id_wr_data),
        .id_q    (id_q)
    );

    // Poison word: the agent ID in its field, every other bit zero.
    always_comb begin
        mark_word                      = '0;
        mark_word[ID_MSB:MARK_ID_LSB]  = id_q;
    end

    odm_checkgen #(.DW(DW), .CW(CW)) u_gen_in (
        .data  (in_data),
        .check (gen_in)
    );

    odm_checkgen #(.DW(DW), .CW(CW)) u_gen_mark (
        .data  (mark_word),
        .check (gen_mark)
    );

    odm_select #(.DW(DW), .CW(CW), .MARK_SYN(MARK_SYN)) u_sel (
        .status     (in_status),
        .cacheable  (in_cacheable),
        .in_data    (in_data),
        .in_check   (in_check),
        .gen_in     (gen_in),
        .mark_word  (mark_word),
        .gen_mark   (gen_mark),
        .nxt_data   (nxt_data),
        .nxt_check  (nxt_check),
        .nxt_report (nxt_report)
    );

    // The stage can take a beat when it is empty or is being drained.
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Valid flag of the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    // Payload of the output stage, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_check  <= '0;
            out_report <= 2'd0;
        end else if (accept) begin
            out_data   <= nxt_data;
            out_check  <= nxt_check;
            out_report <= nxt_report;
        end
    end

endmodule

// File: rtl/odm_marker_chk.sv
// Module: odm_marker_chk
// Assertion checker bound to odm_marker. It watches the ports and the agent
// ID register.
// Assumes a synchronous active-low reset. All properties are disabled in reset.
module odm_marker_chk #(
    parameter int DW          = 64,
    parameter int CW          = 8,
    parameter int IDW         = 8,
    parameter int MARK_ID_LSB = 48
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [DW-1:0]  in_data,
    input logic [CW-1:0]  in_check,
    input logic [1:0]     in_status,
    input logic           in_cacheable,
    input logic           out_valid,
    input logic           out_ready,
    input logic [DW-1:0]  out_data,
    input logic [CW-1:0]  out_check,
    input logic [1:0]     out_report,
    input logic [IDW-1:0] id_q
);

    logic acc;
    assign acc = in_valid && in_ready;

    // R7: an accepted beat is presented after the same edge.
    p_latency_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    // R8: a stalled beat holds its payload and blocks input.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_check) && $stable(out_report)));

    p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R3: already-marked beats leave verbatim.
    p_marked_verbatim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_status == 2'd3) |=>
            (out_data == $past(in_data) && out_check == $past(in_check)));

    // R4: raw beats carry the agent ID in the field, zero elsewhere.
    p_raw_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_status == 2'd2) |=>
            (out_data == (DW'($past(id_q)) << MARK_ID_LSB)));

    // R6: report mode follows status and cacheability.
    p_report_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_report == ($past(in_status[1]) ?
                                ($past(in_cacheable) ? 2'd2 : 2'd1) : 2'd0)));

    // R2: clean and correctable beats keep their data word.
    p_clean_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_status[1]) |=> (out_data == $past(in_data)));

endmodule

bind odm_marker odm_marker_chk #(
    .DW(DW), .CW(CW), .IDW(IDW), .MARK_ID_LSB(MARK_ID_LSB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .in_check     (in_check),
    .in_status    (in_status),
    .in_cacheable (in_cacheable),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_check    (out_check),
    .out_report   (out_report),
    .id_q         (id_q)
);

// File: tb/odm_marker_test.sv
// Bench for odm_marker: a vector table walked by one loop, then directed
// tests for reset, the ID register and backpressure.
module odm_marker_test;

    localparam int             DW   = 64;
    localparam int             CW   = 8;
    localparam int             IDW  = 8;
    localparam int             LSB  = 40;
    localparam logic [7:0]     SYN  = 8'hC3;
    localparam logic [7:0]     RID  = 8'h3C;
    localparam int             NV   = 8;

    // Expected check kind: 0 regenerated, 1 verbatim, 2 poison code.
    localparam logic [63:0] V_DATA [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'hDEAD_BEEF_0000_0000, 64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_1234,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000 };
    localparam logic [7:0] V_CHK  [NV] = '{8'h00, 8'h11, 8'h12, 8'hFF, 8'h00, 8'h55, 8'h7E, 8'h99};
    localparam logic [1:0] V_ST   [NV] = '{2'd0, 2'd1, 2'd3, 2'd3, 2'd2, 2'd2, 2'd0, 2'd1};
    localparam logic       V_CACH [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [63:0] E_DATA [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000,
        64'hDEAD_BEEF_0000_0000, 64'h0000_0000_0000_0000,
        64'h0000_3C00_0000_0000, 64'h0000_3C00_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000 };
    localparam int         E_KIND [NV] = '{0, 0, 1, 1, 2, 2, 0, 0};
    localparam logic [1:0] E_REP  [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd0, 2'd0};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           id_wr_en = 1'b0;
    logic [IDW-1:0] id_wr_data = '0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [DW-1:0]  in_data = '0;
    logic [CW-1:0]  in_check = '0;
    logic [1:0]     in_status = '0;
    logic           in_cacheable = 1'b0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [DW-1:0]  out_data;
    logic [CW-1:0]  out_check;
    logic [1:0]     out_report;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    odm_marker #(
        .DW(DW), .CW(CW), .IDW(IDW), .MARK_ID_LSB(LSB),
        .MARK_SYN(SYN), .RESET_ID(RID)
    ) uut (
        .clk(clk), .rst_n(rst_n), .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_check(in_check), .in_status(in_status), .in_cacheable(in_cacheable),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_check(out_check), .out_report(out_report)
    );

    // Check code written from the R2 definition.
    function automatic logic [7:0] code_of(input logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < 7; k++) begin
                if ((((i + 1) >> k) & 1) != 0) c[k] ^= d[i];
            end
            c[7] ^= d[i];
        end
        return c;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Offer one beat with the output side ready, then sample after the edge.
    task automatic send(input logic [63:0] d, input logic [7:0] c,
                        input logic [1:0] s, input logic ca);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_check = c;
        in_status = s; in_cacheable = ca;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset.
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "in_ready", 64'(in_ready), 64'd1);

        // Table walk: R2, R3, R4 (with the reset ID from R1), R6, R7.
        for (int v = 0; v < NV; v++) begin
            logic [7:0] ec;
            send(V_DATA[v], V_CHK[v], V_ST[v], V_CACH[v]);
            ec = (E_KIND[v] == 0) ? code_of(E_DATA[v]) :
                 (E_KIND[v] == 1) ? V_CHK[v] : (code_of(E_DATA[v]) ^ SYN);
            check("R7", "out_valid", 64'(out_valid), 64'd1);
            check(E_KIND[v] == 0 ? "R2" : E_KIND[v] == 1 ? "R3" : "R4",
                  "out_data", out_data, E_DATA[v]);
            check(E_KIND[v] == 0 ? "R2" : E_KIND[v] == 1 ? "R3" : "R4",
                  "out_check", 64'(out_check), 64'(ec));
            check("R6", "out_report", 64'(out_report), 64'(E_REP[v]));
        end
        @(negedge clk);
        check("R7", "drained", 64'(out_valid), 64'd0);

        // R5: write a new ID, then mark a raw beat with it.
        @(negedge clk);
        id_wr_en = 1'b1; id_wr_data = 8'hA7;
        @(negedge clk);
        id_wr_en = 1'b0;
        send(64'h1, 8'h0, 2'd2, 1'b0);
        check("R5", "new id", out_data, 64'h0000_A700_0000_0000);
        check("R5", "new id check", 64'(out_check),
              64'(code_of(64'h0000_A700_0000_0000) ^ SYN));

        // R5: a write on the same edge as acceptance leaves the old ID in use.
        @(negedge clk);
        id_wr_en = 1'b1; id_wr_data = 8'h5E;
        in_valid = 1'b1; in_data = '1; in_status = 2'd2; in_cacheable = 1'b1;
        @(negedge clk);
        id_wr_en = 1'b0; in_valid = 1'b0;
        check("R5", "same-edge old id", out_data, 64'h0000_A700_0000_0000);
        send(64'h2, 8'h0, 2'd2, 1'b1);
        check("R5", "id after write", out_data, 64'h0000_5E00_0000_0000);

        // R8: stall with a beat held, offer a second one, then release.
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 64'hAAAA; in_check = 8'h01;
        in_status = 2'd3; in_cacheable = 1'b0;
        @(negedge clk);
        in_data = 64'hBBBB; in_check = 8'h02; in_status = 2'd0; in_cacheable = 1'b1;
        check("R8", "in_ready low", 64'(in_ready), 64'd0);
        @(negedge clk);
        check("R8", "held data", out_data, 64'hAAAA);
        check("R8", "held check", 64'(out_check), 64'h01);
        check("R8", "held report", 64'(out_report), 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "second beat valid", 64'(out_valid), 64'd1);
        check("R8", "second beat data", out_data, 64'hBBBB);
        check("R2", "second beat check", 64'(out_check), 64'(code_of(64'hBBBB)));
        @(negedge clk);
        check("R8", "no duplicate", 64'(out_valid), 64'd0);

        // R1: reset restores the ID register.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
        send(64'h3, 8'h0, 2'd2, 1'b0);
        check("R1", "reset id", out_data, 64'h0000_3C00_0000_0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule